// File: doc/BRIEF.md
# Thread Block Admission Allocator

This block sits at the launch port of a multithreaded multiprocessor. Each request describes one thread block: an identifier, how many threads it has, how many registers each thread needs and how many bytes of on-chip shared memory it needs. The allocator admits a block only if it fits every space budget at once. Those budgets are free warp slots, free register-file entries, free shared-memory bytes and a free entry in the resident-block table. An admitted block keeps its resources until a completion for its identifier arrives.

Requests use valid/ready handshaking and are served strictly in arrival order. A legal request that does not fit holds `req_ready` low until a completion frees enough space. A request that could never be legal is consumed at once and answered with a reject pulse. Each grant returns the table slot and the index of the first warp of a contiguous run of warp slots. The current occupancy of every budget is always visible on registered outputs.

Top module: `launch_gate`

## Requirements
- R1: After synchronous reset, all four occupancy outputs read 0 and neither `gnt_valid` nor `rej_valid` is asserted.
- R2: A request with a thread count of 0 or above 512 is accepted (`req_ready` high). In the next cycle `rej_valid` pulses with `rej_id` equal to the request ID, and the occupancy does not change.
- R3: A request is rejected in the same way as in R2 if threads × registers-per-thread exceeds 16384, or if its shared-memory byte count exceeds 16384.
- R4: A granted block is charged ceil(threads/32) warps, and `occ_warps` rises by that amount in the cycle after the grant.
- R5: A granted block is charged threads × registers-per-thread registers and its full shared-memory byte count. `occ_regs` and `occ_smem` rise by those amounts in the cycle after the grant.
- R6: A legal request that exceeds any remaining budget sees `req_ready` low and changes no state. It is held at the head until it fits, and no later request overtakes it.
- R7: A grant pulses `gnt_valid` one cycle after acceptance. It carries `gnt_id`, `gnt_slot` and `gnt_warp`. `gnt_slot` is the lowest free table slot (0 to 7). `gnt_warp` is the lowest warp index (0 to 31) that starts a run of free warp slots long enough for the block.
- R8: At most 8 blocks are resident. With 8 resident, a legal request is held even when warps, registers and shared memory would suffice.
- R9: A completion (`done_valid` with `done_id`) that matches a resident block returns all of that block's warps, registers, shared memory and slot, visible in the next cycle. A completion with an ID that matches no resident block has no effect.
- R10: If a grant and a completion fall on the same clock edge, both take effect. The admission decision and the choice of placement are made on the occupancy before the release.
- R11: `occ_warps` never exceeds 32, `occ_regs` never exceeds 16384, `occ_smem` never exceeds 16384 and `occ_blocks` never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Request consumed this cycle (grant or reject) |
| req_id | input | 6 | Block identifier |
| req_threads | input | 10 | Threads in the block |
| req_rpt | input | 8 | Registers per thread |
| req_smem | input | 16 | Shared-memory bytes requested |
| done_valid | input | 1 | Completion strobe |
| done_id | input | 6 | Identifier of the completed block |
| gnt_valid | output | 1 | Grant pulse |
| gnt_id | output | 6 | Identifier of the granted block |
| gnt_slot | output | 3 | Table slot assigned |
| gnt_warp | output | 5 | First warp index assigned |
| rej_valid | output | 1 | Reject pulse |
| rej_id | output | 6 | Identifier of the rejected request |
| occ_warps | output | 6 | Warp slots in use |
| occ_regs | output | 15 | Registers in use |
| occ_smem | output | 15 | Shared-memory bytes in use |
| occ_blocks | output | 4 | Resident blocks |

## Verification
An admission and a release can land on the same clock edge. The bench provokes this by presenting a fitting request in the same cycle as a completion for another resident block. It then checks two things. First, the grant takes the slot and warp run that were free before the release. Second, the next-cycle occupancy equals the old value plus the new block's charge minus the finished block's charge. A held request that turns ready only after a release covers the neighbouring case, where the release lands one edge before the admission.

// File: rtl/launch_gate_pkg.sv
package launch_gate_pkg;
  typedef enum logic [1:0] {
    DEC_IDLE   = 2'd0,
    DEC_HOLD   = 2'd1,
    DEC_GRANT  = 2'd2,
    DEC_REJECT = 2'd3
  } decision_e;
endpackage

// File: rtl/lg_cost.sv
module lg_cost #(
  parameter int MAX_THREADS = 512,
  parameter int WARP_SIZE   = 32,
  parameter int NUM_WARPS   = 32,
  parameter int NUM_REGS    = 16384,
  parameter int SMEM_BYTES  = 16384,
  parameter int TH_W        = 10,
  parameter int RPT_W       = 8,
  parameter int SMEM_REQ_W  = 16,
  parameter int WCNT_W      = 6,
  localparam int PROD_W     = TH_W + RPT_W
) (
  input  logic [TH_W-1:0]       threads,
  input  logic [RPT_W-1:0]      rpt,
  input  logic [SMEM_REQ_W-1:0] smem,
  output logic [WCNT_W-1:0]     need_warps,
  output logic [PROD_W-1:0]     need_regs,
  output logic                  illegal
);
  localparam int WS_SH = $clog2(WARP_SIZE);
  logic [TH_W:0] rounded;

  always_comb begin
    rounded    = {1'b0, threads} + (TH_W+1)'(WARP_SIZE - 1);
    need_warps = WCNT_W'(rounded >> WS_SH);
    need_regs  = PROD_W'(threads) * PROD_W'(rpt);
    illegal    = (threads == '0)
              || (threads > TH_W'(MAX_THREADS))
              || (need_warps > WCNT_W'(NUM_WARPS))
              || (need_regs > PROD_W'(NUM_REGS))
              || (smem > SMEM_REQ_W'(SMEM_BYTES));
  end
endmodule

// File: rtl/lg_warp_finder.sv
module lg_warp_finder #(
  parameter int NUM_WARPS = 32,
  parameter int WCNT_W    = 6,
  parameter int WIDX_W    = 5
) (
  input  logic [NUM_WARPS-1:0] busy,
  input  logic [WCNT_W-1:0]    need,
  output logic                 found,
  output logic [WIDX_W-1:0]    start,
  output logic [NUM_WARPS-1:0] win
);
  logic [NUM_WARPS-1:0] low_ones;
  logic [NUM_WARPS-1:0] cand;

  always_comb begin
    low_ones = ~({NUM_WARPS{1'b1}} << need);
    found    = 1'b0;
    start    = '0;
    win      = '0;
    cand     = '0;
    // scan downward so the lowest fitting start is the last one kept
    for (int s = NUM_WARPS - 1; s >= 0; s--) begin
      cand = low_ones << s;
      if ((need != '0) && ((s + int'(need)) <= NUM_WARPS) && ((busy & cand) == '0)) begin
        found = 1'b1;
        start = WIDX_W'(s);
        win   = cand;
      end
    end
  end
endmodule

// File: rtl/lg_slot_table.sv
module lg_slot_table #(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = 6,
  parameter int WIDX_W    = 5,
  parameter int WCNT_W    = 6,
  parameter int REG_W     = 15,
  parameter int SMEM_W    = 15,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [ID_W-1:0]   alloc_id,
  input  logic [WIDX_W-1:0] alloc_first,
  input  logic [WCNT_W-1:0] alloc_warps,
  input  logic [REG_W-1:0]  alloc_regs,
  input  logic [SMEM_W-1:0] alloc_smem,
  input  logic              rel_en,
  input  logic [ID_W-1:0]   rel_id,
  output logic              free_found,
  output logic [SLOT_W-1:0] free_slot,
  output logic              rel_hit,
  output logic [WIDX_W-1:0] rel_first,
  output logic [WCNT_W-1:0] rel_warps,
  output logic [REG_W-1:0]  rel_regs,
  output logic [SMEM_W-1:0] rel_smem
);
  logic [NUM_SLOTS-1:0] live;
  logic [ID_W-1:0]      t_id    [NUM_SLOTS];
  logic [WIDX_W-1:0]    t_first [NUM_SLOTS];
  logic [WCNT_W-1:0]    t_warps [NUM_SLOTS];
  logic [REG_W-1:0]     t_regs  [NUM_SLOTS];
  logic [SMEM_W-1:0]    t_smem  [NUM_SLOTS];
  logic [SLOT_W-1:0]    rel_slot;

  always_comb begin
    free_found = 1'b0;
    free_slot  = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (!live[s]) begin
        free_found = 1'b1;
        free_slot  = SLOT_W'(s);
      end
    end
  end

  always_comb begin
    rel_hit  = 1'b0;
    rel_slot = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (live[s] && (t_id[s] == rel_id)) begin
        rel_hit  = 1'b1;
        rel_slot = SLOT_W'(s);
      end
    end
  end

  assign rel_first = t_first[rel_slot];
  assign rel_warps = t_warps[rel_slot];
  assign rel_regs  = t_regs[rel_slot];
  assign rel_smem  = t_smem[rel_slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
    end else begin
      if (alloc_en)          live[free_slot] <= 1'b1;
      if (rel_en && rel_hit) live[rel_slot]  <= 1'b0;
    end
  end

  // payload arrays carry no reset so they map onto plain storage
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      t_id[free_slot]    <= alloc_id;
      t_first[free_slot] <= alloc_first;
      t_warps[free_slot] <= alloc_warps;
      t_regs[free_slot]  <= alloc_regs;
      t_smem[free_slot]  <= alloc_smem;
    end
  end
endmodule

// File: rtl/launch_gate.sv
module launch_gate
  import launch_gate_pkg::*;
#(
  parameter int MAX_THREADS = 512,
  parameter int WARP_SIZE   = 32,
  parameter int NUM_WARPS   = 32,
  parameter int NUM_REGS    = 16384,
  parameter int SMEM_BYTES  = 16384,
  parameter int NUM_SLOTS   = 8,
  parameter int ID_W        = 6,
  parameter int RPT_W       = 8,
  localparam int TH_W       = $clog2(MAX_THREADS + 1),
  localparam int SMEM_W     = $clog2(SMEM_BYTES + 1),
  localparam int SMEM_REQ_W = SMEM_W + 1,
  localparam int REG_W      = $clog2(NUM_REGS + 1),
  localparam int WCNT_W     = $clog2(NUM_WARPS + 1),
  localparam int WIDX_W     = $clog2(NUM_WARPS),
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int BCNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ID_W-1:0]       req_id,
  input  logic [TH_W-1:0]       req_threads,
  input  logic [RPT_W-1:0]      req_rpt,
  input  logic [SMEM_REQ_W-1:0] req_smem,
  input  logic                  done_valid,
  input  logic [ID_W-1:0]       done_id,
  output logic                  gnt_valid,
  output logic [ID_W-1:0]       gnt_id,
  output logic [SLOT_W-1:0]     gnt_slot,
  output logic [WIDX_W-1:0]     gnt_warp,
  output logic                  rej_valid,
  output logic [ID_W-1:0]       rej_id,
  output logic [WCNT_W-1:0]     occ_warps,
  output logic [REG_W-1:0]      occ_regs,
  output logic [SMEM_W-1:0]     occ_smem,
  output logic [BCNT_W-1:0]     occ_blocks
);
  localparam int PROD_W = TH_W + RPT_W;

  function automatic logic [NUM_WARPS-1:0] win_mask(input logic [WIDX_W-1:0] st,
                                                     input logic [WCNT_W-1:0] n);
    return (~({NUM_WARPS{1'b1}} << n)) << st;
  endfunction

  logic [NUM_WARPS-1:0] busy;
  logic [WCNT_W-1:0]    need_warps;
  logic [PROD_W-1:0]    need_regs;
  logic                 illegal;
  logic                 warp_found;
  logic [WIDX_W-1:0]    warp_start;
  logic [NUM_WARPS-1:0] warp_win;
  logic                 free_found;
  logic [SLOT_W-1:0]    free_slot;
  logic                 rel_hit;
  logic [WIDX_W-1:0]    rel_first;
  logic [WCNT_W-1:0]    rel_warps;
  logic [REG_W-1:0]     rel_regs;
  logic [SMEM_W-1:0]    rel_smem;
  logic [PROD_W:0]      regs_sum;
  logic [SMEM_REQ_W:0]  smem_sum;
  logic                 fit;
  logic                 take;
  logic                 drop;
  decision_e            dec;

  lg_cost #(
    .MAX_THREADS(MAX_THREADS), .WARP_SIZE(WARP_SIZE), .NUM_WARPS(NUM_WARPS),
    .NUM_REGS(NUM_REGS), .SMEM_BYTES(SMEM_BYTES), .TH_W(TH_W), .RPT_W(RPT_W),
    .SMEM_REQ_W(SMEM_REQ_W), .WCNT_W(WCNT_W)
  ) cost_i (
    .threads(req_threads), .rpt(req_rpt), .smem(req_smem),
    .need_warps(need_warps), .need_regs(need_regs), .illegal(illegal)
  );

  lg_warp_finder #(
    .NUM_WARPS(NUM_WARPS), .WCNT_W(WCNT_W), .WIDX_W(WIDX_W)
  ) finder_i (
    .busy(busy), .need(need_warps),
    .found(warp_found), .start(warp_start), .win(warp_win)
  );

  lg_slot_table #(
    .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .WIDX_W(WIDX_W), .WCNT_W(WCNT_W),
    .REG_W(REG_W), .SMEM_W(SMEM_W)
  ) table_i (
    .clk(clk), .rst(rst),
    .alloc_en(take), .alloc_id(req_id), .alloc_first(warp_start),
    .alloc_warps(need_warps), .alloc_regs(REG_W'(need_regs)),
    .alloc_smem(SMEM_W'(req_smem)),
    .rel_en(done_valid), .rel_id(done_id),
    .free_found(free_found), .free_slot(free_slot), .rel_hit(rel_hit),
    .rel_first(rel_first), .rel_warps(rel_warps),
    .rel_regs(rel_regs), .rel_smem(rel_smem)
  );

  always_comb begin
    regs_sum = (PROD_W+1)'(occ_regs) + (PROD_W+1)'(need_regs);
    smem_sum = (SMEM_REQ_W+1)'(occ_smem) + (SMEM_REQ_W+1)'(req_smem);
    fit = free_found && warp_found
       && (regs_sum <= (PROD_W+1)'(NUM_REGS))
       && (smem_sum <= (SMEM_REQ_W+1)'(SMEM_BYTES));
    if (!req_valid)   dec = DEC_IDLE;
    else if (illegal) dec = DEC_REJECT;
    else if (fit)     dec = DEC_GRANT;
    else              dec = DEC_HOLD;
  end

  assign req_ready = illegal || fit;
  assign take      = (dec == DEC_GRANT);
  assign drop      = done_valid && rel_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= '0;
      occ_warps  <= '0;
      occ_regs   <= '0;
      occ_smem   <= '0;
      occ_blocks <= '0;
      gnt_valid  <= 1'b0;
      rej_valid  <= 1'b0;
      gnt_id     <= '0;
      gnt_slot   <= '0;
      gnt_warp   <= '0;
      rej_id     <= '0;
    end else begin
      busy <= (busy | (take ? warp_win : '0))
            & ~(drop ? win_mask(rel_first, rel_warps) : '0);
      occ_warps  <= occ_warps + (take ? need_warps : '0) - (drop ? rel_warps : '0);
      occ_regs   <= occ_regs + (take ? REG_W'(need_regs) : '0) - (drop ? rel_regs : '0);
      occ_smem   <= occ_smem + (take ? SMEM_W'(req_smem) : '0) - (drop ? rel_smem : '0);
      occ_blocks <= occ_blocks + (take ? BCNT_W'(1) : '0) - (drop ? BCNT_W'(1) : '0);
      gnt_valid  <= take;
      rej_valid  <= (dec == DEC_REJECT);
      if (take) begin
        gnt_id   <= req_id;
        gnt_slot <= free_slot;
        gnt_warp <= warp_start;
      end
      if (dec == DEC_REJECT) rej_id <= req_id;
    end
  end
endmodule

// File: rtl/lg_checker.sv
module lg_checker #(
  parameter int NUM_WARPS  = 32,
  parameter int NUM_REGS   = 16384,
  parameter int SMEM_BYTES = 16384,
  parameter int NUM_SLOTS  = 8,
  parameter int TH_W       = 10,
  parameter int WCNT_W     = 6,
  parameter int REG_W      = 15,
  parameter int SMEM_W     = 15,
  parameter int BCNT_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [TH_W-1:0]   req_threads,
  input logic              done_valid,
  input logic              gnt_valid,
  input logic              rej_valid,
  input logic [WCNT_W-1:0] occ_warps,
  input logic [REG_W-1:0]  occ_regs,
  input logic [SMEM_W-1:0] occ_smem,
  input logic [BCNT_W-1:0] occ_blocks
);
  a_r11_warp_cap: assert property (@(posedge clk) disable iff (rst)
    occ_warps <= WCNT_W'(NUM_WARPS));
  a_r11_reg_cap: assert property (@(posedge clk) disable iff (rst)
    occ_regs <= REG_W'(NUM_REGS));
  a_r11_smem_cap: assert property (@(posedge clk) disable iff (rst)
    occ_smem <= SMEM_W'(SMEM_BYTES));
  a_r8_slot_cap: assert property (@(posedge clk) disable iff (rst)
    occ_blocks <= BCNT_W'(NUM_SLOTS));
  a_r2_zero_threads: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_threads == '0) |=> (rej_valid && !gnt_valid));
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !done_valid) |=>
      ($stable(occ_warps) && $stable(occ_regs) && $stable(occ_smem)
       && $stable(occ_blocks) && !gnt_valid && !rej_valid));
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(gnt_valid && rej_valid));
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!gnt_valid && !rej_valid));
endmodule

bind launch_gate lg_checker #(
  .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .SMEM_BYTES(SMEM_BYTES),
  .NUM_SLOTS(NUM_SLOTS), .TH_W(TH_W), .WCNT_W(WCNT_W), .REG_W(REG_W),
  .SMEM_W(SMEM_W), .BCNT_W(BCNT_W)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_threads(req_threads), .done_valid(done_valid), .gnt_valid(gnt_valid),
  .rej_valid(rej_valid), .occ_warps(occ_warps), .occ_regs(occ_regs),
  .occ_smem(occ_smem), .occ_blocks(occ_blocks)
);

// File: tb/launch_gate_tb_top.sv
module launch_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, done_valid;
  logic [5:0]  req_id, done_id;
  logic [9:0]  req_threads;
  logic [7:0]  req_rpt;
  logic [15:0] req_smem;
  logic        gnt_valid, rej_valid;
  logic [5:0]  gnt_id, rej_id;
  logic [2:0]  gnt_slot;
  logic [4:0]  gnt_warp;
  logic [5:0]  occ_warps;
  logic [14:0] occ_regs, occ_smem;
  logic [3:0]  occ_blocks;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  launch_gate dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_threads(req_threads), .req_rpt(req_rpt),
    .req_smem(req_smem), .done_valid(done_valid), .done_id(done_id),
    .gnt_valid(gnt_valid), .gnt_id(gnt_id), .gnt_slot(gnt_slot),
    .gnt_warp(gnt_warp), .rej_valid(rej_valid), .rej_id(rej_id),
    .occ_warps(occ_warps), .occ_regs(occ_regs), .occ_smem(occ_smem),
    .occ_blocks(occ_blocks)
  );

  // kind: 0 grant, 1 thread-range reject, 2 capacity reject
  typedef struct packed {
    logic [5:0]  id;
    logic [9:0]  thr;
    logic [7:0]  rpt;
    logic [15:0] sm;
    logic [1:0]  kind;
    logic [2:0]  slot;
    logic [4:0]  warp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{6'd1, 10'd64,  8'd16, 16'd1024,  2'd0, 3'd0, 5'd0},
    '{6'd2, 10'd0,   8'd4,  16'd0,     2'd1, 3'd0, 5'd0},
    '{6'd3, 10'd513, 8'd1,  16'd0,     2'd1, 3'd0, 5'd0},
    '{6'd4, 10'd33,  8'd10, 16'd0,     2'd0, 3'd1, 5'd2},
    '{6'd5, 10'd512, 8'd40, 16'd0,     2'd2, 3'd0, 5'd0},
    '{6'd6, 10'd1,   8'd1,  16'd16385, 2'd2, 3'd0, 5'd0},
    '{6'd7, 10'd512, 8'd16, 16'd4096,  2'd0, 3'd2, 5'd4},
    '{6'd8, 10'd32,  8'd8,  16'd2048,  2'd0, 3'd3, 5'd20}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic occ_chk(input string tag, input int w, input int r, input int s, input int b);
    chk({tag, " warps"},  int'(occ_warps),  w);
    chk({tag, " regs"},   int'(occ_regs),   r);
    chk({tag, " smem"},   int'(occ_smem),   s);
    chk({tag, " blocks"}, int'(occ_blocks), b);
  endtask

  task automatic put_req(input int id, input int thr, input int rpt, input int sm);
    req_id      = 6'(id);
    req_threads = 10'(thr);
    req_rpt     = 8'(rpt);
    req_smem    = 16'(sm);
    req_valid   = 1'b1;
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic send_grant(input string tag, input int id, input int thr, input int rpt,
                            input int sm, input int slot, input int warp);
    put_req(id, thr, rpt, sm);
    #1 chk({tag, " ready"}, int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk({tag, " gnt_valid"}, int'(gnt_valid), 1);
    chk({tag, " gnt_id"},    int'(gnt_id),    id);
    chk({tag, " gnt_slot"},  int'(gnt_slot),  slot);
    chk({tag, " gnt_warp"},  int'(gnt_warp),  warp);
  endtask

  task automatic pulse_done(input int id);
    done_id    = 6'(id);
    done_valid = 1'b1;
    @(negedge clk);
    done_valid = 1'b0;
    #1;
  endtask

  initial begin
    #(20 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0; done_valid = 1'b0;
    req_id = '0; req_threads = '0; req_rpt = '0; req_smem = '0; done_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    occ_chk("R1 reset", 0, 0, 0, 0);
    chk("R1 gnt idle", int'(gnt_valid), 0);
    chk("R1 rej idle", int'(rej_valid), 0);

    // vector walk from an empty multiprocessor
    for (int i = 0; i < 8; i++) begin
      string tag;
      tag = (VEC[i].kind == 2'd0) ? "R7" : ((VEC[i].kind == 2'd1) ? "R2" : "R3");
      @(negedge clk);
      if (VEC[i].kind == 2'd0) begin
        send_grant($sformatf("%s vec%0d", tag, i), int'(VEC[i].id), int'(VEC[i].thr),
                   int'(VEC[i].rpt), int'(VEC[i].sm), int'(VEC[i].slot), int'(VEC[i].warp));
      end else begin
        put_req(int'(VEC[i].id), int'(VEC[i].thr), int'(VEC[i].rpt), int'(VEC[i].sm));
        #1 chk($sformatf("%s vec%0d ready", tag, i), int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk($sformatf("%s vec%0d rej_valid", tag, i), int'(rej_valid), 1);
        chk($sformatf("%s vec%0d rej_id", tag, i), int'(rej_id), int'(VEC[i].id));
        chk($sformatf("%s vec%0d no grant", tag, i), int'(gnt_valid), 0);
      end
    end
    occ_chk("R4 R5 after walk", 21, 9802, 7168, 4);

    // R6: register budget too small, held until block 7 completes
    @(negedge clk);
    put_req(9, 256, 32, 0);
    for (int k = 0; k < 3; k++) begin
      #1 chk("R6 held ready", int'(req_ready), 0);
      @(negedge clk);
    end
    occ_chk("R6 held stable", 21, 9802, 7168, 4);
    done_id = 6'd7;
    done_valid = 1'b1;
    #1 chk("R6 still held", int'(req_ready), 0);
    @(negedge clk);
    done_valid = 1'b0;
    #1;
    occ_chk("R9 release", 5, 1610, 3072, 3);
    chk("R6 ready after release", int'(req_ready), 1);
    chk("R6 no early grant", int'(gnt_valid), 0);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R6 gnt_valid", int'(gnt_valid), 1);
    chk("R6 gnt_id", int'(gnt_id), 9);
    chk("R7 reused slot", int'(gnt_slot), 2);
    chk("R7 reused warp", int'(gnt_warp), 4);
    occ_chk("R5 after held grant", 13, 9802, 3072, 4);

    // R9: unknown identifier
    @(negedge clk);
    pulse_done(63);
    occ_chk("R9 unknown id", 13, 9802, 3072, 4);

    // R7: first fit skips a run that is too short
    @(negedge clk);
    send_grant("R7 skip short run", 10, 288, 1, 0, 4, 21);
    @(negedge clk);
    send_grant("R7 fill gap", 11, 256, 1, 0, 5, 12);
    occ_chk("R4 after fit", 30, 10346, 3072, 6);

    // R10: grant and release on the same edge
    @(negedge clk);
    put_req(12, 32, 4, 512);
    done_id = 6'd4;
    done_valid = 1'b1;
    #1 chk("R10 ready", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    done_valid = 1'b0;
    #1;
    chk("R10 gnt_valid", int'(gnt_valid), 1);
    chk("R10 pre-release slot", int'(gnt_slot), 6);
    chk("R10 pre-release warp", int'(gnt_warp), 30);
    occ_chk("R10 net occupancy", 29, 10144, 3584, 6);

    @(negedge clk);
    send_grant("R7 lowest freed run", 13, 64, 1, 0, 1, 2);
    @(negedge clk);
    send_grant("R7 last warp", 14, 1, 1, 0, 7, 31);
    chk("R11 warps full", int'(occ_warps), 32);

    @(negedge clk);
    pulse_done(10);
    occ_chk("R9 release mid", 23, 9921, 3584, 7);
    @(negedge clk);
    send_grant("R7 refill slot", 15, 32, 1, 0, 4, 21);

    // R8: eight resident, warps still free, request must wait
    @(negedge clk);
    put_req(16, 32, 1, 0);
    for (int k = 0; k < 3; k++) begin
      #1 chk("R8 slot limit ready", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    #1;
    chk("R8 no grant", int'(gnt_valid), 0);
    occ_chk("R8 stable", 24, 9953, 3584, 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule